// File: doc/BRIEF.md
# Serial-Addressed Octal Register Bank

This block is the digital front end of an eight-channel trim converter. A host writes to it over three wires: a serial clock, a serial data line and a load strobe. Each write is a 12-bit word that lands in a shift register. The word carries a 4-bit channel address followed by an 8-bit value. On a load strobe the value is copied into one of eight holding registers, and the eight register values drive the converter channels.

The far end of the shift register is driven out unchanged on a serial output. Several banks can therefore share one clock and one strobe, each one's serial output feeding the next one's serial input. An active-low preset line forces every holding register to mid-scale (0x80) at once, without waiting for a clock. The three interface lines are brought into the fast system clock domain through two-flop synchronizers, and all actions fire on detected edges.

Top module: `serialRegBank`

## Requirements
- R1: After system reset every holding register reads 0x80 and the shift register is all zeros, so the serial output reads 0.
- R2: Each rising serial-clock edge seen while the load strobe is low and preset is released shifts one bit in from serial data. The first bit sent ends up as the most significant bit of the 12-bit word.
- R3: On a rising edge of the load strobe, the word's upper 4 bits (A3..A0) select the channel and its lower 8 bits (D7..D0) are written to it. Codes 1 through 8 select channels 0 through 7, and every other channel keeps its value.
- R4: Address codes 0 and 9 through 15 are no-operation codes: a load with one of them changes no holding register.
- R5: While the load strobe is high, serial-clock edges and serial data are ignored and the shift register does not move.
- R6: A low preset forces all eight registers to 0x80 asynchronously. While it is low, it overrides both load and shift: loads write nothing and clock edges shift nothing.
- R7: The serial output is the shift register's most significant bit. A bit entering at serial data appears there after twelve shifting edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| serClk | input | 1 | Serial clock from the host, asynchronous |
| serData | input | 1 | Serial data, sampled on serial-clock rising edges |
| loadStrobe | input | 1 | Load strobe, active high; its rising edge commits the word |
| presetN | input | 1 | Asynchronous active-low mid-scale preset |
| serOut | output | 1 | Tail of the shift register, for daisy-chaining |
| chanFlat | output | 64 | Eight 8-bit channel values, channel 0 in bits 7:0 |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 8-bit values, eight channels and two synchronizer stages. At this size every address code can be swept. Each legal code writes its own channel while a reference model confirms the other seven, and each of the eight no-operation codes is shown to leave all channels untouched. The small word length also lets the bench follow every one of the twelve shift positions at the serial output. It further checks that clock edges are ignored both during a held load strobe and during an active preset.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;
  // Control strobes handed from the edge-detect control to the datapath.
  typedef struct packed {
    logic shiftEn;  // one-cycle pulse: shift one bit in
    logic loadEn;   // one-cycle pulse: commit word to the addressed channel
  } bankStrobes_t;
endpackage

// File: rtl/serialBankCtrl.sv
module serialBankCtrl
  import serial_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serData,
  input  logic         loadStrobe,
  input  logic         presetN,
  output bankStrobes_t strb,
  output logic         bitIn
);
  localparam int LINES = 4;  // {presetN, loadStrobe, serData, serClk}
  localparam int LAST  = SYNC_STAGES - 1;

  logic [LINES-1:0] syncPipe [SYNC_STAGES];
  logic             clkPrev, ldPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= {presetN, loadStrobe, serData, serClk};
  end

  genvar s;
  generate
    for (s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else       syncPipe[s] <= syncPipe[s-1];
      end
    end
  endgenerate

  logic clkNow, dataNow, ldNow, preOk;
  assign clkNow  = syncPipe[LAST][0];
  assign dataNow = syncPipe[LAST][1];
  assign ldNow   = syncPipe[LAST][2];
  assign preOk   = syncPipe[LAST][3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      ldPrev  <= 1'b0;
    end else begin
      clkPrev <= clkNow;
      ldPrev  <= ldNow;
    end
  end

  always_comb begin
    strb.shiftEn = clkNow & ~clkPrev & ~ldNow & preOk;
    strb.loadEn  = ldNow & ~ldPrev & preOk;
    bitIn        = dataNow;
  end

  // A held strobe commits once: a load pulse is never followed by another.
  p_load_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> !strb.loadEn);

endmodule

// File: rtl/serialBankPath.sv
module serialBankPath
  import serial_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     presetN,
  input  bankStrobes_t             strb,
  input  logic                     bitIn,
  output logic                     serOut,
  output logic [NUM_CH*DATA_W-1:0] chanFlat
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addrField;
  logic [DATA_W-1:0] dataField;
  logic [DATA_W-1:0] bank [NUM_CH];

  assign addrField = shiftReg[WORD_W-1 -: ADDR_W];
  assign dataField = shiftReg[DATA_W-1:0];
  assign serOut    = shiftReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], bitIn};
  end

  // Bits move up one place and the new bit lands at the bottom.
  p_shift_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (shiftReg[0] == $past(bitIn)) &&
                     (shiftReg[WORD_W-1:1] == $past(shiftReg[WORD_W-2:0])));

  // A load pulse never moves the shift register.
  p_load_no_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && !strb.shiftEn) |=> $stable(shiftReg));

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_chan
      localparam logic [ADDR_W-1:0] MY_CODE = ADDR_W'(g + 1);
      logic hit;
      assign hit = strb.loadEn && (addrField == MY_CODE);

      always_ff @(posedge clk or negedge rstN or negedge presetN) begin
        if (!rstN || !presetN) bank[g] <= MID_CODE;
        else if (hit)          bank[g] <= dataField;
      end

      assign chanFlat[g*DATA_W +: DATA_W] = bank[g];

      p_chan_write_r3: assert property (@(posedge clk) disable iff (!rstN)
        (strb.loadEn && presetN && addrField == MY_CODE) |=>
          (!presetN || bank[g] == $past(dataField)));

      p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
        (presetN && !(strb.loadEn && addrField == MY_CODE)) |=>
          (!presetN || $stable(bank[g])));

      p_preset_mid_r6: assert property (@(posedge clk) disable iff (!rstN)
        !presetN |-> bank[g] == MID_CODE);
    end
  endgenerate

endmodule

// File: rtl/serialRegBank.sv
module serialRegBank
  import serial_bank_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     loadStrobe,
  input  logic                     presetN,
  output logic                     serOut,
  output logic [NUM_CH*DATA_W-1:0] chanFlat
);
  bankStrobes_t strb;
  logic         bitIn;

  serialBankCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadStrobe(loadStrobe), .presetN(presetN), .strb(strb), .bitIn(bitIn)
  );

  serialBankPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_path (
    .clk(clk), .rstN(rstN), .presetN(presetN), .strb(strb), .bitIn(bitIn),
    .serOut(serOut), .chanFlat(chanFlat)
  );
endmodule

// File: tb/tb_serialRegBank.sv
module tb_serialRegBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, loadStrobe = 1'b0, presetN = 1'b1;
  logic serOut;
  logic [63:0] chanFlat;

  int checks = 0, failures = 0;
  logic [7:0] model [8];
  logic       done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  serialRegBank dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadStrobe(loadStrobe), .presetN(presetN), .serOut(serOut),
    .chanFlat(chanFlat)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    waitClk(4);
    serClk = 1'b1;
    waitClk(6);
    serClk = 1'b0;
    waitClk(6);
  endtask

  task automatic sendWord(input logic [3:0] addr, input logic [7:0] data);
    logic [11:0] w;
    w = {addr, data};
    for (int i = 11; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLoad();
    loadStrobe = 1'b1;
    waitClk(8);
    loadStrobe = 1'b0;
    waitClk(8);
  endtask

  task automatic checkAll(input string req);
    for (int c = 0; c < 8; c++) check(req, 32'(chanFlat[c*8 +: 8]), 32'(model[c]));
  endtask

  initial begin
    waitClk(20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] pat;
    for (int c = 0; c < 8; c++) model[c] = 8'h80;
    waitClk(3);
    rstN = 1'b1;
    waitClk(5);

    // R1: reset state, and an all-zero shift register loads as a no-op
    checkAll("R1");
    check("R1", 32'(serOut), 0);
    pulseLoad();
    checkAll("R1");

    // R3: every legal code writes its channel; the others keep their values
    for (int a = 1; a <= 8; a++) begin
      logic [7:0] v;
      v = 8'((a * 37 + 11) & 255);
      sendWord(4'(a), v);
      pulseLoad();
      model[a-1] = v;
      checkAll("R3");
    end
    // R3: extreme data patterns on one channel
    foreach (pat[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h55 : 8'hAA;
      sendWord(4'd5, v);
      pulseLoad();
      model[4] = v;
      check("R3", 32'(chanFlat[4*8 +: 8]), 32'(v));
    end

    // R4: no-operation codes 0 and 9..15
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a >= 9) begin
        sendWord(4'(a), 8'h5A);
        pulseLoad();
        checkAll("R4");
      end
    end

    // R2/R7: known word, then watch each bit reach the serial output
    pat = 12'hB2D;
    for (int i = 11; i >= 0; i--) sendBit(pat[i]);
    for (int j = 0; j < 12; j++) begin
      check("R7", 32'(serOut), 32'(pat[11-j]));
      sendBit(1'b0);
    end
    check("R2", 32'(serOut), 0);

    // R5: clock edges ignored while the load strobe is high
    sendWord(4'd1, 8'h33);
    loadStrobe = 1'b1;
    waitClk(8);
    for (int t = 0; t < 5; t++) begin
      serData = 1'b1;
      waitClk(3);
      serClk = 1'b1;
      waitClk(6);
      serClk = 1'b0;
      waitClk(6);
    end
    check("R5", 32'(serOut), 0);
    loadStrobe = 1'b0;
    waitClk(8);
    model[0] = 8'h33;
    pulseLoad();  // re-commits the same word only if nothing shifted
    check("R5", 32'(chanFlat[7:0]), 32'h33);
    checkAll("R5");

    // R6: asynchronous preset, overriding shift and load
    sendWord(4'd2, 8'h44);
    #1 presetN = 1'b0;
    #1;
    for (int c = 0; c < 8; c++) model[c] = 8'h80;
    checkAll("R6");
    sendBit(1'b1);
    sendBit(1'b1);
    pulseLoad();
    checkAll("R6");
    presetN = 1'b1;
    waitClk(8);
    checkAll("R6");
    pulseLoad();  // shift register still holds channel 1 word
    model[1] = 8'h44;
    checkAll("R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule